// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block watches sixteen external request lines and records each rising edge on them in a sticky status flag. Software reads the flags through a small 32-bit register interface. It clears a flag by writing a one to that flag's bit, and a zero leaves the bit as it was. A second register holds one enable bit per channel and decides which flags may raise requests.

Every channel whose flag and enable are both set drives its own request output, which can serve as a DMA trigger. The OR of all these channel requests forms one combined interrupt line to the interrupt controller. The raw inputs are asynchronous to the block clock. Each one passes through a two-flop synchronizer before edge detection. Every register access finishes in a single cycle, and read data is combinational from the registered state.

Top module: `ext_irq_flags`

## Requirements
- R1: Each of the 16 inputs goes through a two-flop synchronizer. A rising edge on input n sets flag n on the third rising clock edge after the input changes, and not before.
- R2: A falling edge, or an input held high, does not set a flag. An input that stays high after its flag is cleared does not set the flag again.
- R3: The status register is at offset 0x14. Flag n is in read bit n (bits 15:0). Bits 31:16 read as 0, and writes to them have no effect.
- R4: A set flag stays set until software clears it.
- R5: Writing 1 to bit n at offset 0x14 clears flag n. Writing 0 to bit n leaves flag n unchanged.
- R6: The enable register is at offset 0x18. Bits 15:0 are read/write enable bits, one per channel. Bits 31:16 read as 0 and ignore writes.
- R7: After reset, all flags, all enables and all request outputs are 0.
- R8: `irq_req` is 1 exactly when at least one channel has both its flag and its enable set.
- R9: `chan_req[n]` equals flag n AND enable n.
- R10: If an edge event and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R11: Reads from any offset other than 0x14 and 0x18 return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_in | input | 16 | Raw asynchronous request inputs |
| irq_req | output | 1 | Combined request to the interrupt controller |
| chan_req | output | 16 | Per-channel requests (flag AND enable) |

## Verification
Single-channel pulses on the lowest, highest and a middle channel tie each input to its own bit position. Sampling one cycle before and one cycle after the expected set edge pins down the synchronizer latency. A level held high across a clear, and a lone falling edge, separate true edge detection from level sensing. Clear-write patterns that mix ones and zeros show that only the addressed flags drop. A clear timed to land in the same cycle as a fresh edge shows that the set takes priority. Enable patterns that cover some flags and miss others check the per-channel gating and the combined OR.

// File: rtl/eif_pkg.sv
package eif_pkg;
  localparam int NUM_CH    = 16;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int SYNC_DEPTH = 2;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h18;

  typedef logic [NUM_CH-1:0] ch_vec_t;
  typedef logic [DATA_W-1:0] word_t;

  // channel field of a register word (channel n at bit n)
  function automatic ch_vec_t field_of(input word_t w);
    return w[NUM_CH-1:0];
  endfunction

  // place a channel vector into a register word, upper bits zero
  function automatic word_t word_of(input ch_vec_t v);
    word_t w;
    w = '0;
    w[NUM_CH-1:0] = v;
    return w;
  endfunction

  // next flag state: clear by write-one, new events win
  function automatic ch_vec_t flag_next(input ch_vec_t cur, input ch_vec_t clr,
                                        input ch_vec_t evt);
    return (cur & ~clr) | evt;
  endfunction
endpackage

// File: rtl/eif_edge_sync.sv
module eif_edge_sync #(
  parameter int NUM_CH = eif_pkg::NUM_CH,
  parameter int DEPTH  = eif_pkg::SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw_in,
  output logic [NUM_CH-1:0] rise_evt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DEPTH-1:0] stage;
    logic             last_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage  <= '0;
        last_q <= 1'b0;
      end else begin
        stage  <= {stage[DEPTH-2:0], raw_in[c]};
        last_q <= stage[DEPTH-1];
      end
    end
    assign rise_evt[c] = stage[DEPTH-1] & ~last_q;
  end
endmodule

// File: rtl/eif_flag_bank.sv
module eif_flag_bank #(
  parameter int NUM_CH = eif_pkg::NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_evt,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= eif_pkg::flag_next(flags, clr_mask, set_evt);
  end
endmodule

// File: rtl/eif_enable_reg.sv
module eif_enable_reg #(
  parameter int NUM_CH = eif_pkg::NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_val,
  output logic [NUM_CH-1:0] enables
);
  always_ff @(posedge clk) begin
    if (!rst_n)     enables <= '0;
    else if (wr_en) enables <= wr_val;
  end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
  import eif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] irq_in,
  output logic              irq_req,
  output logic [NUM_CH-1:0] chan_req
);
  // named internal events for the checker
  logic    hit_status, hit_enable;
  logic    wr_status, wr_enable;
  ch_vec_t edge_vec, clr_vec, flag_q, en_q;
  logic    unused_hi;

  assign hit_status = (reg_addr == OFF_STATUS);
  assign hit_enable = (reg_addr == OFF_ENABLE);
  assign wr_status  = reg_we & hit_status;
  assign wr_enable  = reg_we & hit_enable;
  assign clr_vec    = wr_status ? field_of(reg_wdata) : '0;
  assign unused_hi  = ^reg_wdata[DATA_W-1:NUM_CH];

  eif_edge_sync #(.NUM_CH(NUM_CH), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(irq_in), .rise_evt(edge_vec)
  );

  eif_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(edge_vec), .clr_mask(clr_vec), .flags(flag_q)
  );

  eif_enable_reg #(.NUM_CH(NUM_CH)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_enable), .wr_val(field_of(reg_wdata)),
    .enables(en_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_status)      reg_rdata = word_of(flag_q);
    else if (hit_enable) reg_rdata = word_of(en_q);
  end

  assign chan_req = flag_q & en_q;
  assign irq_req  = |chan_req;
endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk
  import eif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_status,
  input logic              wr_enable,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NUM_CH-1:0] edge_vec,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] en_q,
  input logic              irq_req,
  input logic [NUM_CH-1:0] chan_req
);
  // R1 / R10: an event always leaves its flag set next cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_vec) |=> ((flag_q & $past(edge_vec)) == $past(edge_vec)));

  // R4 / R5: a flag only drops when its bit was written with one
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_status) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R5: a write-one clears the bits that saw no event
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> ((flag_q & $past(reg_wdata[NUM_CH-1:0] & ~edge_vec)) == '0));

  // R6: enable write takes the low field
  a_r6_enable_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> (en_q == $past(reg_wdata[NUM_CH-1:0])));

  // R3 / R6: upper read bits are always zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_CH] == '0);

  // R8 / R9: combined line follows the per-channel requests
  a_r8_combined: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (chan_req != '0));

  // R9: no channel request without its enable
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req & ~en_q) == '0);
endmodule

bind ext_irq_flags ext_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_status(wr_status), .wr_enable(wr_enable),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .edge_vec(edge_vec),
  .flag_q(flag_q), .en_q(en_q), .irq_req(irq_req), .chan_req(chan_req)
);

// File: tb/ext_irq_flags_bench.sv
`timescale 1ns/1ps
module ext_irq_flags_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_in = '0;
  logic        irq_req;
  logic [15:0] chan_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] A_ST = 8'h14;
  localparam logic [7:0] A_EN = 8'h18;

  always #2.5 clk = ~clk;

  ext_irq_flags u_ext_irq_flags (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .irq_req(irq_req), .chan_req(chan_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    repeat (4) @(negedge clk);
    irq_in = irq_in & ~m;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    rd(A_ST, d); check("R7 status", d, 0);
    rd(A_EN, d); check("R7 enable", d, 0);
    check("R7 requests", {15'b0, irq_req, chan_req}, 0);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    @(negedge clk);
    irq_in[7] = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_ST, d); check("R1 not yet", d, 0);
    @(negedge clk);
    rd(A_ST, d); check("R1 set on third edge", d, 32'h80);
    irq_in[7] = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_ST, d); check("R4 stays after fall", d, 32'h80);
    wr(A_ST, 32'h80);
    rd(A_ST, d); check("R5 clear", d, 0);
  endtask

  task automatic t_positions;
    logic [31:0] d;
    pulse(16'h0001);
    rd(A_ST, d); check("R3 channel 0 bit", d, 32'h1);
    pulse(16'h8000);
    rd(A_ST, d); check("R3 channel 15 bit", d, 32'h8001);
    wr(A_ST, 32'hFFFF_0000);
    rd(A_ST, d); check("R3 upper write ignored", d, 32'h8001);
    wr(A_ST, 32'h0000_0001);
    rd(A_ST, d); check("R5 zero bits keep", d, 32'h8000);
    wr(A_ST, 32'h0000_8000);
    rd(A_ST, d); check("R5 clear ch15", d, 0);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    @(negedge clk);
    irq_in[3] = 1'b1;
    repeat (4) @(negedge clk);
    wr(A_ST, 32'h8);
    repeat (4) @(negedge clk);
    rd(A_ST, d); check("R2 held level no reset", d, 0);
    irq_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_ST, d); check("R2 falling edge ignored", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    pulse(16'h0024);
    check("R8 no enable no irq", {31'b0, irq_req}, 0);
    wr(A_EN, 32'hABCD_0010);
    rd(A_EN, d); check("R6 readback upper zero", d, 32'h0010);
    check("R8 disjoint enable", {31'b0, irq_req}, 0);
    wr(A_EN, 32'h0000_0024);
    check("R9 per-channel", {16'b0, chan_req}, 32'h24);
    check("R8 combined", {31'b0, irq_req}, 1);
    wr(A_ST, 32'h4);
    check("R9 after clear", {16'b0, chan_req}, 32'h20);
    wr(A_ST, 32'h20);
    check("R8 drops", {31'b0, irq_req}, 0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    pulse(16'h0060);
    @(negedge clk);
    irq_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    reg_addr = A_ST; reg_wdata = 32'h60; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(A_ST, d); check("R10 set wins, other cleared", d, 32'h20);
    irq_in[5] = 1'b0;
    wr(A_ST, 32'h20);
  endtask

  task automatic t_other;
    logic [31:0] d;
    pulse(16'h0100);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R11 other reads zero", d, 0);
    rd(A_ST, d); check("R11 status untouched", d, 32'h100);
    rd(A_EN, d); check("R11 enable untouched", d, 0);
    wr(A_ST, 32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_positions();
    t_levels();
    t_enable();
    t_collision();
    t_other();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule